// File: doc/BRIEF.md
# Egress Lane Parity Regenerator

This block sits on one PCS lane at the exit of a transport network, after trans-decoding. Each cycle it can take one 66-bit block in two forms: the descrambled block and the rescrambled block. A marker strobe closes the current parity window. When a marker arrives, the block also receives the carried marker fields. These are three lane-identity bytes, the ingress lane parity, the parity computed over the transport section, and the error mask found at ingress.

The block keeps two running bit-interleaved parities. The first runs over the descrambled stream and opens with a rebuilt copy of the ingress marker. Comparing it with the received transport parity gives a transport error mask. The second runs over the rescrambled stream that leaves the block. At each marker the block takes this fresh parity, XORs in the ingress mask and the transport mask, and sends a new marker that carries the corrected parity and its inverse. Downstream monitors therefore see every error made along the full path. The number of set bits in the combined mask is added to a saturating per-lane error counter.

Top module: `ebip_egress_regen`

## Requirements
- R1: Parity over a 66-bit block works as follows. Block bit 0 toggles parity bit 3 and block bit 1 toggles parity bit 4. Each block bit k from 2 to 65 toggles parity bit (k-2) mod 8.
- R2: A marker block holds its sync field 2'b01 in bits [1:0] and byte n in bits [2+8n +: 8]. The bytes are ID0, ID1, ID2, P, ~ID0, ~ID1, ~ID2, ~P. The outgoing marker uses the incoming ID bytes and P = adjusted parity. The rebuilt ingress marker uses P = received ingress parity.
- R3: On a marker, `xport_mask` becomes the parity of the descrambled blocks in the current window XOR `mrk_xport_bip`. The window starts with the previous rebuilt ingress marker, or is empty after reset.
- R4: The adjusted parity equals the rescrambled-window parity XOR `comb_mask`, where `comb_mask` = `mrk_pcs_mask` XOR transport mask. The rescrambled window starts with the previous outgoing marker.
- R5: A valid data block appears on `out_blk` one cycle later as its rescrambled form, with `out_vld`=1 and `out_mrk`=0. A marker appears one cycle later with `out_mrk`=1.
- R6: On each marker, `err_cnt` grows by the number of set bits in the combined mask (0 to 8).
- R7: `err_cnt` saturates at its all-ones value.
- R8: A cycle with `in_vld`=0 produces no output, leaves the masks and the counter unchanged, and adds nothing to either parity window.
- R9: After reset, `out_vld`, `out_mrk`, `out_blk`, both masks and `err_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input block valid |
| in_mrk | input | 1 | Input block is a marker (closes window) |
| in_plain_blk | input | 66 | Trans-decoded descrambled block |
| in_scr_blk | input | 66 | Rescrambled block |
| mrk_id0 | input | 8 | Marker identity byte 0 |
| mrk_id1 | input | 8 | Marker identity byte 1 |
| mrk_id2 | input | 8 | Marker identity byte 2 |
| mrk_ing_bip | input | 8 | Ingress lane parity from the marker |
| mrk_xport_bip | input | 8 | Received transport-section parity |
| mrk_pcs_mask | input | 8 | Error mask found at ingress |
| out_vld | output | 1 | Output block valid |
| out_mrk | output | 1 | Output block is the regenerated marker |
| out_blk | output | 66 | Output block |
| xport_mask | output | 8 | Transport error mask of last marker |
| comb_mask | output | 8 | Combined error mask of last marker |
| err_cnt | output | CNT_W | Saturating parity error count |

## Verification
A wrong parity accumulator state stays hidden while data flows. It shows only at the next marker, one cycle after the strobe: the transport mask or the adjusted parity in `out_blk` differs, and so the counter increment differs too. The directed tests therefore close windows with known contents, including single-bit blocks that pin down the interleaving. They also insert idle cycles with garbage inputs, so that a window polluted by those cycles shows up at the following marker. A counter fault appears in the cycle after a marker, or only near the ceiling, so the tests drive the counter into saturation.

// File: rtl/ebip_pkg.sv
package ebip_pkg;
  localparam int BLK_W  = 66;
  localparam int BIP_W  = 8;
  localparam int SYNC_W = 2;
  localparam logic [SYNC_W-1:0] SYNC_CTRL = 2'b01;

  typedef logic [BLK_W-1:0] blk_t;
  typedef logic [BIP_W-1:0] bip_t;

  // Interleaved parity of one block: sync bits land on parity bits 3 and 4
  function automatic bip_t bip_fold(input blk_t b);
    bip_t p;
    p = '0;
    p[3] = p[3] ^ b[0];
    p[4] = p[4] ^ b[1];
    for (int k = SYNC_W; k < BLK_W; k++) begin
      p[3'((k - SYNC_W) % BIP_W)] = p[3'((k - SYNC_W) % BIP_W)] ^ b[k];
    end
    return p;
  endfunction

  // Marker layout: id bytes, parity, then their inverses
  function automatic blk_t mk_marker(input bip_t id0, input bip_t id1,
                                     input bip_t id2, input bip_t par);
    return {~par, ~id2, ~id1, ~id0, par, id2, id1, id0, SYNC_CTRL};
  endfunction

  function automatic logic [3:0] pop8(input bip_t v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < BIP_W; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/ebip_par_acc.sv
module ebip_par_acc
  import ebip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic blk_en,
  input  logic win_load,
  input  blk_t load_blk,
  input  blk_t data_blk,
  output bip_t acc_o
);
  bip_t acc_q, acc_d;
  logic acc_ce;

  assign acc_ce = blk_en | win_load;

  always_comb begin
    acc_d = acc_q;
    if (win_load)    acc_d = bip_fold(load_blk);
    else if (blk_en) acc_d = acc_q ^ bip_fold(data_blk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R8: idle cycles leave the window untouched
  a_r8_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_en && !win_load) |=> $stable(acc_o));
endmodule

// File: rtl/ebip_mrk_gen.sv
module ebip_mrk_gen
  import ebip_pkg::*;
(
  input  bip_t id0,
  input  bip_t id1,
  input  bip_t id2,
  input  bip_t ing_bip,
  input  bip_t rx_xport_bip,
  input  bip_t pcs_mask,
  input  bip_t plain_par,
  input  bip_t scr_par,
  output blk_t rebuilt_blk,
  output blk_t regen_blk,
  output bip_t xmask,
  output bip_t cmask
);
  bip_t adj_bip;

  always_comb begin
    xmask       = plain_par ^ rx_xport_bip;
    cmask       = pcs_mask ^ xmask;
    adj_bip     = scr_par ^ cmask;
    rebuilt_blk = mk_marker(id0, id1, id2, ing_bip);
    regen_blk   = mk_marker(id0, id1, id2, adj_bip);
  end
endmodule

// File: rtl/ebip_err_cnt.sv
module ebip_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [3:0]       add_val,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int SUM_W = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + SUM_W'(add_val);
    cnt_d = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (add_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R7: once at the ceiling, stays there
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o == CNT_MAX) |=> (cnt_o == CNT_MAX));
  // R6: a marker adds at most eight and never decreases the count
  a_r6_bounded_step: assert property (@(posedge clk) disable iff (!rst_n)
    add_en |=> (cnt_o >= $past(cnt_o)) && ((cnt_o - $past(cnt_o)) <= CNT_W'(8)));
  // R8: no marker, no change
  a_r8_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !add_en |=> $stable(cnt_o));
endmodule

// File: rtl/ebip_egress_regen.sv
module ebip_egress_regen
  import ebip_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic             in_mrk,
  input  logic [65:0]      in_plain_blk,
  input  logic [65:0]      in_scr_blk,
  input  logic [7:0]       mrk_id0,
  input  logic [7:0]       mrk_id1,
  input  logic [7:0]       mrk_id2,
  input  logic [7:0]       mrk_ing_bip,
  input  logic [7:0]       mrk_xport_bip,
  input  logic [7:0]       mrk_pcs_mask,
  output logic             out_vld,
  output logic             out_mrk,
  output logic [65:0]      out_blk,
  output logic [7:0]       xport_mask,
  output logic [7:0]       comb_mask,
  output logic [CNT_W-1:0] err_cnt
);
  logic mrk_take, data_take;
  bip_t plain_par, scr_par, xmask_c, cmask_c;
  blk_t rebuilt_blk, regen_blk;

  logic vld_q, mrk_q;
  blk_t blk_q, blk_d;
  bip_t xm_q, xm_d, cm_q, cm_d;

  assign mrk_take  = in_vld & in_mrk;
  assign data_take = in_vld & ~in_mrk;

  ebip_par_acc i_plain_acc (
    .clk(clk), .rst_n(rst_n), .blk_en(data_take), .win_load(mrk_take),
    .load_blk(rebuilt_blk), .data_blk(in_plain_blk), .acc_o(plain_par));

  ebip_par_acc i_scr_acc (
    .clk(clk), .rst_n(rst_n), .blk_en(data_take), .win_load(mrk_take),
    .load_blk(regen_blk), .data_blk(in_scr_blk), .acc_o(scr_par));

  ebip_mrk_gen i_mrk_gen (
    .id0(mrk_id0), .id1(mrk_id1), .id2(mrk_id2), .ing_bip(mrk_ing_bip),
    .rx_xport_bip(mrk_xport_bip), .pcs_mask(mrk_pcs_mask),
    .plain_par(plain_par), .scr_par(scr_par),
    .rebuilt_blk(rebuilt_blk), .regen_blk(regen_blk),
    .xmask(xmask_c), .cmask(cmask_c));

  ebip_err_cnt #(.CNT_W(CNT_W)) i_err_cnt (
    .clk(clk), .rst_n(rst_n), .add_en(mrk_take),
    .add_val(pop8(cmask_c)), .cnt_o(err_cnt));

  always_comb begin
    blk_d = mrk_take ? regen_blk : in_scr_blk;
    xm_d  = mrk_take ? xmask_c : xm_q;
    cm_d  = mrk_take ? cmask_c : cm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      mrk_q <= 1'b0;
      blk_q <= '0;
      xm_q  <= '0;
      cm_q  <= '0;
    end else begin
      vld_q <= in_vld;
      mrk_q <= mrk_take;
      if (in_vld) blk_q <= blk_d;
      if (mrk_take) begin
        xm_q <= xm_d;
        cm_q <= cm_d;
      end
    end
  end

  assign out_vld    = vld_q;
  assign out_mrk    = mrk_q;
  assign out_blk    = blk_q;
  assign xport_mask = xm_q;
  assign comb_mask  = cm_q;

  // R5: data blocks leave one cycle later in rescrambled form
  a_r5_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !in_mrk) |=> out_vld && !out_mrk && (out_blk == $past(in_scr_blk)));
  // R2: outgoing marker keeps the control sync field and id bytes
  a_r2_marker_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mrk) |=> out_mrk && (out_blk[1:0] == 2'b01) &&
      (out_blk[25:2] == {$past(mrk_id2), $past(mrk_id1), $past(mrk_id0)}));
  // R4: trailing parity byte is the inverse of the adjusted parity
  a_r4_inverse_par: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_mrk) |-> (out_blk[65:58] == ~out_blk[33:26]));
  // R4: combined mask folds the ingress mask into the transport mask
  a_r4_comb_fold: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_mrk) |=> (comb_mask == (xport_mask ^ $past(mrk_pcs_mask))));
  // R8: idle input gives no output and holds the masks
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld && $stable(xport_mask) && $stable(comb_mask));
endmodule

// File: tb/test_ebip_egress_regen.sv
module test_ebip_egress_regen;
  localparam int CW = 8;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk, rst_n, in_vld, in_mrk;
  logic [65:0] in_plain_blk, in_scr_blk, out_blk;
  logic [7:0] mrk_id0, mrk_id1, mrk_id2, mrk_ing_bip, mrk_xport_bip, mrk_pcs_mask;
  logic out_vld, out_mrk;
  logic [7:0] xport_mask, comb_mask;
  logic [CW-1:0] err_cnt;

  int total = 0;
  int bad = 0;
  logic [7:0] m_plain, m_scr;
  int m_cnt;

  ebip_egress_regen #(.CNT_W(CW)) i_ebip_egress_regen (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_mrk(in_mrk),
    .in_plain_blk(in_plain_blk), .in_scr_blk(in_scr_blk),
    .mrk_id0(mrk_id0), .mrk_id1(mrk_id1), .mrk_id2(mrk_id2),
    .mrk_ing_bip(mrk_ing_bip), .mrk_xport_bip(mrk_xport_bip),
    .mrk_pcs_mask(mrk_pcs_mask), .out_vld(out_vld), .out_mrk(out_mrk),
    .out_blk(out_blk), .xport_mask(xport_mask), .comb_mask(comb_mask),
    .err_cnt(err_cnt));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // R1 parity mapping as written in the requirement
  function automatic logic [7:0] par(input logic [65:0] b);
    logic [7:0] p;
    p = '0;
    p[3] ^= b[0];
    p[4] ^= b[1];
    for (int k = 2; k < 66; k++) p[(k - 2) % 8] ^= b[k];
    return p;
  endfunction

  // R2 marker layout
  function automatic logic [65:0] mkr(input logic [7:0] a, b, c, p);
    return {~p, ~c, ~b, ~a, p, c, b, a, 2'b01};
  endfunction

  function automatic int ones(input logic [7:0] v);
    int n;
    n = 0;
    for (int i = 0; i < 8; i++) n += int'(v[i]);
    return n;
  endfunction

  task automatic chk(input string req, input logic [65:0] act, input logic [65:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n, input logic garbage);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      in_mrk = garbage;
      in_plain_blk = garbage ? {$urandom, $urandom, $urandom} : '0;
      in_scr_blk = garbage ? {$urandom, $urandom, $urandom} : '0;
      mrk_pcs_mask = garbage ? 8'hff : 8'h00;
    end
  endtask

  task automatic send_data(input logic [65:0] p, input logic [65:0] s);
    @(negedge clk);
    in_vld = 1'b1; in_mrk = 1'b0; in_plain_blk = p; in_scr_blk = s;
    @(posedge clk); #1;
    chk("R5 out_vld", {65'd0, out_vld}, 66'd1);
    chk("R5 data block", out_blk, s);
    m_plain ^= par(p);
    m_scr ^= par(s);
  endtask

  task automatic send_mrk(input logic [7:0] a, b, c, ib, xb, pm);
    logic [7:0] xm, cm;
    logic [65:0] exp_blk;
    xm = m_plain ^ xb;
    cm = xm ^ pm;
    exp_blk = mkr(a, b, c, m_scr ^ cm);
    m_cnt = m_cnt + ones(cm);
    if (m_cnt > int'(CMAX)) m_cnt = int'(CMAX);
    @(negedge clk);
    in_vld = 1'b1; in_mrk = 1'b1;
    in_plain_blk = {$urandom, $urandom, $urandom};
    in_scr_blk = {$urandom, $urandom, $urandom};
    mrk_id0 = a; mrk_id1 = b; mrk_id2 = c;
    mrk_ing_bip = ib; mrk_xport_bip = xb; mrk_pcs_mask = pm;
    @(posedge clk); #1;
    chk("R5 marker flag", {64'd0, out_vld, out_mrk}, 66'd3);
    chk("R3 xport_mask", {58'd0, xport_mask}, {58'd0, xm});
    chk("R4 comb_mask", {58'd0, comb_mask}, {58'd0, cm});
    chk("R2 R4 marker block", out_blk, exp_blk);
    chk("R6 err_cnt", {58'd0, err_cnt}, 66'(m_cnt));
    m_plain = par(mkr(a, b, c, ib));
    m_scr = par(exp_blk);
  endtask

  task automatic t_reset;
    chk("R9 out_vld", {64'd0, out_vld, out_mrk}, 66'd0);
    chk("R9 out_blk", out_blk, 66'd0);
    chk("R9 masks", {50'd0, xport_mask, comb_mask}, 66'd0);
    chk("R9 err_cnt", {58'd0, err_cnt}, 66'd0);
  endtask

  task automatic t_first_window;
    send_mrk(8'h11, 8'h22, 8'h33, 8'h5a, 8'h03, 8'h00);
  endtask

  task automatic t_clean_window;
    send_data(66'h2_1234_5678_9abc_def0, 66'h1_0f0f_0f0f_f0f0_f0f0);
    send_data(66'h1_ffff_0000_ffff_0000, 66'h2_aaaa_5555_aaaa_5555);
    send_data(66'h3_0000_0000_0000_0001, 66'h0_8000_0000_0000_0002);
    send_mrk(8'h44, 8'h55, 8'h66, 8'hc3, m_plain, 8'h21);
  endtask

  task automatic t_xport_errors;
    send_data(66'h2_dead_beef_0bad_f00d, 66'h1_cafe_babe_1234_4321);
    send_mrk(8'h77, 8'h88, 8'h99, 8'h0f, m_plain ^ 8'h81, 8'h00);
    send_data(66'h1_0000_ffff_0000_ffff, 66'h1_1111_2222_3333_4444);
    send_mrk(8'h01, 8'h02, 8'h03, 8'hf0, m_plain ^ 8'h0c, 8'h0c);
  endtask

  task automatic t_idle_ignored;
    logic [7:0] xm0, cm0;
    logic [CW-1:0] c0;
    send_data(66'h2_0102_0304_0506_0708, 66'h1_0807_0605_0403_0201);
    xm0 = xport_mask; cm0 = comb_mask; c0 = err_cnt;
    for (int i = 0; i < 4; i++) begin
      idle(1, 1'b1);
      @(posedge clk); #1;
      chk("R8 no output", {65'd0, out_vld}, 66'd0);
      chk("R8 state hold", {42'd0, xport_mask, comb_mask, err_cnt},
          {42'd0, xm0, cm0, c0});
    end
    send_mrk(8'haa, 8'hbb, 8'hcc, 8'h3c, m_plain, 8'h00);
  endtask

  task automatic t_bit_map;
    // After a marker with zero fields the rebuilt window holds parity 8'h08
    send_mrk(8'h00, 8'h00, 8'h00, 8'h00, m_plain, 8'h00);
    send_data(66'h4, 66'h0);
    send_mrk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R1 bit2 to parity0", {58'd0, xport_mask}, 66'h09);
    send_data(66'h2, 66'h0);
    send_data({1'b1, 65'd0}, 66'h0);
    send_mrk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    chk("R1 bit1 bit65 mapping", {58'd0, xport_mask}, 66'h98);
  endtask

  task automatic t_saturation;
    for (int i = 0; i < 40; i++) begin
      send_data({$urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom});
      send_mrk(8'(i), 8'h10, 8'h20, 8'(i * 3), m_plain, 8'hff);
    end
    chk("R7 saturated", {58'd0, err_cnt}, 66'(CMAX));
    send_mrk(8'h5, 8'h6, 8'h7, 8'h8, m_plain ^ 8'h01, 8'h80);
    chk("R7 holds at ceiling", {58'd0, err_cnt}, 66'(CMAX));
  endtask

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; in_mrk = 1'b0;
    in_plain_blk = '0; in_scr_blk = '0;
    mrk_id0 = '0; mrk_id1 = '0; mrk_id2 = '0;
    mrk_ing_bip = '0; mrk_xport_bip = '0; mrk_pcs_mask = '0;
    m_plain = '0; m_scr = '0; m_cnt = 0;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_first_window();
    t_clean_window();
    t_xport_errors();
    idle(2, 1'b0);
    t_idle_ignored();
    t_bit_map();
    t_saturation();
    idle(2, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule